// File: doc/BRIEF.md
# Multi-size shift and rotate unit

This execution unit takes one operand per request and applies an arithmetic shift, a logical shift, a plain rotate or a rotate through the extend flag, in either direction. It works on the low byte, the low word or the full long of a 32-bit operand, and it also offers an operation that exchanges the two 16-bit halves of the operand. The amount to move comes either from a 3-bit field carried with the request or from the low six bits of a count register. A separate memory-operand mode moves a word by exactly one place, as a read-modify-write sequencer needs.

The result and the five condition flags (extend, negative, zero, overflow, carry) are registered. They appear one clock after a request is presented with `valid_i` high and hold until the next request. Bits of the operand above the selected size are returned unchanged, so the caller can write the whole register back. Decode, address calculation, bus cycles and the other condition-code bits are outside the block.

Top module: `shift_rotate_unit`

## Requirements
- R1: A request presented with `valid_i` high is answered one clock later with `valid_o` high; a cycle without a request gives `valid_o` low on the next clock; after reset `valid_o`, `result_o` and all flags are 0.
- R2: `op_i` selects the operation: 0 arithmetic right, 1 arithmetic left, 2 logical right, 3 logical left, 4 extend-rotate right, 5 extend-rotate left, 6 rotate right, 7 rotate left, and any value with bit 3 set is the half swap. `size_i` is 0 for byte, 1 for word, 2 or 3 for long; result bits above the selected size equal the operand bits.
- R3: With `cnt_sel_i` low the count is `cnt_imm_i`, where 0 means 8 and 1 to 7 mean themselves; with `cnt_sel_i` high the count is `cnt_reg_i` (0 to 63).
- R4: Logical shifts fill with zeros; a count at or above the operand width gives a zero result; carry and extend take the last bit shifted out (0 when the count exceeds the width).
- R5: Arithmetic right shift fills with the sign bit; a count at or above the width gives all sign bits and carry and extend equal the sign.
- R6: Overflow is 1 after an arithmetic left shift whose most significant bit changes at any step, and 0 after every other operation.
- R7: Plain rotates use the count modulo the operand width, set carry to the last bit rotated out (0 for a zero count) and leave extend equal to `x_i`.
- R8: Extend-rotates rotate the operand together with `x_i` as one value one bit wider than the operand, using the count modulo width plus one; extend and carry both take the bit that ends up in the extend position.
- R9: With a count of zero, the result equals the operand, carry is 0 and extend equals `x_i`, except for extend-rotates, where carry equals `x_i`.
- R10: With `mem_mode_i` high the size is word and the count is one, whatever `size_i`, `cnt_sel_i`, `cnt_imm_i` and `cnt_reg_i` hold.
- R11: The half swap returns operand bits 15:0 in result bits 31:16 and bits 31:16 in bits 15:0; negative is result bit 31, zero is set for an all-zero result, overflow and carry are 0, extend equals `x_i`.
- R12: Negative is the top bit of the selected size of the result and zero is set when the selected size of the result is all zeros.
- R13: A word rotate in either direction with an immediate count of 8 exchanges the two bytes of the low word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 4 | Operation select |
| size_i | input | 2 | Operand size select |
| mem_mode_i | input | 1 | One-bit word move for memory operands |
| cnt_sel_i | input | 1 | 1: count from register, 0: from immediate field |
| cnt_imm_i | input | 3 | Immediate count field, 0 encodes 8 |
| cnt_reg_i | input | 6 | Low six bits of the count register |
| operand_i | input | 32 | Operand |
| x_i | input | 1 | Current extend flag |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Result, upper bits passed through |
| x_o | output | 1 | Extend flag out |
| n_o | output | 1 | Negative flag out |
| z_o | output | 1 | Zero flag out |
| v_o | output | 1 | Overflow flag out |
| c_o | output | 1 | Carry flag out |

## Verification
The hardest outcomes to reach are the count boundaries of each size: a register count equal to the width, one above it, and the width-plus-one wrap of an extend-rotate, together with arithmetic left shifts whose sign changes only on the last step. Uniform random counts and operands rarely land on these, so the random generator biases a quarter of register counts to the band around the selected width and mixes all-ones, sign-only and single-bit operands into the stream. Directed requests cover the zero count per operation class, the immediate encoding of 8, the word byte swap and memory mode with a misleading count and size on the other inputs.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [2:0] {
    SH_ASR  = 3'd0,
    SH_ASL  = 3'd1,
    SH_LSR  = 3'd2,
    SH_LSL  = 3'd3,
    SH_ROXR = 3'd4,
    SH_ROXL = 3'd5,
    SH_ROR  = 3'd6,
    SH_ROL  = 3'd7
  } lane_op_e;

  localparam int unsigned SWAP_BIT  = 3;
  localparam int unsigned NUM_SIZES = 3;
  localparam int unsigned CNT_W     = 6;
  localparam int unsigned IMM_W     = 3;
  localparam logic [1:0]  IDX_WORD  = 2'd1;
endpackage

// File: rtl/sru_decode.sv
module sru_decode
  import sru_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic             mem_mode_i,
  input  logic             cnt_sel_i,
  input  logic [IMM_W-1:0] cnt_imm_i,
  input  logic [CNT_W-1:0] cnt_reg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [1:0]       size_idx_o
);
  localparam logic [CNT_W-1:0] IMM_ZERO_CNT = CNT_W'(1 << IMM_W);

  logic [CNT_W-1:0] imm_cnt;

  assign imm_cnt = (cnt_imm_i == '0) ? IMM_ZERO_CNT : CNT_W'(cnt_imm_i);

  always_comb begin
    if (mem_mode_i) begin
      cnt_o      = CNT_W'(1);
      size_idx_o = IDX_WORD;
    end else begin
      cnt_o      = cnt_sel_i ? cnt_reg_i : imm_cnt;
      size_idx_o = size_i[1] ? 2'd2 : {1'b0, size_i[0]};
    end
  end
endmodule

// File: rtl/sru_lane.sv
module sru_lane
  import sru_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]     v_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  lane_op_e         op_i,
  input  logic             x_i,
  output logic [W-1:0]     res_o,
  output logic             c_o,
  output logic             x_o,
  output logic             v_o
);
  localparam int unsigned L  = W + 1;
  localparam int unsigned AW = CNT_W + 1;
  localparam logic [W-1:0] ONES = '1;

  logic [AW-1:0] cnt_w, r_p, r_x;
  logic          nz;
  assign cnt_w = {1'b0, cnt_i};
  assign r_p   = cnt_w % AW'(W);
  assign r_x   = cnt_w % AW'(L);
  assign nz    = |cnt_i;

  // shifts carry one extra bit to capture the last bit moved out
  logic [W:0]        lsl_t, lsr_t;
  logic signed [W:0] asr_t;
  assign lsl_t = {1'b0, v_i} << cnt_i;
  assign lsr_t = {v_i, 1'b0} >> cnt_i;
  assign asr_t = $signed({v_i, 1'b0}) >>> cnt_i;

  logic [W-1:0] rol_t, ror_t;
  assign rol_t = (v_i << r_p) | (v_i >> (AW'(W) - r_p));
  assign ror_t = (v_i >> r_p) | (v_i << (AW'(W) - r_p));

  logic [L-1:0] ext, roxl_t, roxr_t;
  assign ext    = {x_i, v_i};
  assign roxl_t = (ext << r_x) | (ext >> (AW'(L) - r_x));
  assign roxr_t = (ext >> r_x) | (ext << (AW'(L) - r_x));

  // overflow: top cnt+1 bits not uniform, or anything set when all bits leave
  logic [W-1:0] hi_mask, hi_bits;
  logic         asl_ovf;
  assign hi_mask = ~(ONES >> (cnt_w + AW'(1)));
  assign hi_bits = v_i & hi_mask;
  assign asl_ovf = (cnt_w >= AW'(W)) ? (|v_i)
                                     : ((hi_bits != '0) && (hi_bits != hi_mask));

  always_comb begin
    res_o = v_i;
    c_o   = 1'b0;
    x_o   = x_i;
    unique case (op_i)
      SH_ASL, SH_LSL: begin
        res_o = lsl_t[W-1:0];
        c_o   = lsl_t[W];
        x_o   = nz ? lsl_t[W] : x_i;
      end
      SH_LSR: begin
        res_o = lsr_t[W:1];
        c_o   = lsr_t[0];
        x_o   = nz ? lsr_t[0] : x_i;
      end
      SH_ASR: begin
        res_o = asr_t[W:1];
        c_o   = asr_t[0];
        x_o   = nz ? asr_t[0] : x_i;
      end
      SH_ROL: begin
        res_o = rol_t;
        c_o   = nz & rol_t[0];
      end
      SH_ROR: begin
        res_o = ror_t;
        c_o   = nz & ror_t[W-1];
      end
      SH_ROXL: begin
        res_o = roxl_t[W-1:0];
        c_o   = roxl_t[W];
        x_o   = roxl_t[W];
      end
      SH_ROXR: begin
        res_o = roxr_t[W-1:0];
        c_o   = roxr_t[W];
        x_o   = roxr_t[W];
      end
      default: ;
    endcase
  end

  assign v_o = (op_i == SH_ASL) & asl_ovf;

  // R9: a zero count on a plain shift must leave the lane operand untouched
  always_comb begin
    if (!nz && (op_i != SH_ROXL) && (op_i != SH_ROXR))
      assert_zero_cnt_keeps_R9: assert (res_o == v_i && !c_o);
  end
endmodule

// File: rtl/sru_core.sv
module sru_core
  import sru_pkg::*;
#(
  parameter int unsigned DATA_W = 8 << (NUM_SIZES - 1)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        size_idx_i,
  input  lane_op_e          op_i,
  input  logic              x_i,
  output logic [DATA_W-1:0] full_o,
  output logic              x_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o
);
  logic [DATA_W-1:0] lane_full [NUM_SIZES];
  logic              lane_x    [NUM_SIZES];
  logic              lane_n    [NUM_SIZES];
  logic              lane_z    [NUM_SIZES];
  logic              lane_v    [NUM_SIZES];
  logic              lane_c    [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int unsigned LW = 8 << g;
    localparam logic [DATA_W-1:0] MASK = {DATA_W{1'b1}} >> (DATA_W - LW);
    logic [LW-1:0] lres;

    sru_lane #(.W(LW)) u_lane (
      .v_i   (operand_i[LW-1:0]),
      .cnt_i (cnt_i),
      .op_i  (op_i),
      .x_i   (x_i),
      .res_o (lres),
      .c_o   (lane_c[g]),
      .x_o   (lane_x[g]),
      .v_o   (lane_v[g])
    );

    assign lane_full[g] = (operand_i & ~MASK) | DATA_W'(lres);
    assign lane_n[g]    = lres[LW-1];
    assign lane_z[g]    = (lres == '0);
  end

  always_comb begin
    full_o = operand_i;
    x_o    = x_i;
    n_o    = 1'b0;
    z_o    = 1'b0;
    v_o    = 1'b0;
    c_o    = 1'b0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (size_idx_i == 2'(k)) begin
        full_o = lane_full[k];
        x_o    = lane_x[k];
        n_o    = lane_n[k];
        z_o    = lane_z[k];
        v_o    = lane_v[k];
        c_o    = lane_c[k];
      end
    end
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int unsigned DATA_W = 8 << (NUM_SIZES - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              mem_mode_i,
  input  logic              cnt_sel_i,
  input  logic [IMM_W-1:0]  cnt_imm_i,
  input  logic [CNT_W-1:0]  cnt_reg_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              x_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              x_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [CNT_W-1:0]  cnt;
  logic [1:0]        size_idx;
  lane_op_e          lane_op;
  logic [DATA_W-1:0] core_full, swapped, res_d;
  logic              core_x, core_n, core_z, core_v, core_c;
  logic              is_swap, x_d, n_d, z_d, v_d, c_d;

  assign lane_op = lane_op_e'(op_i[2:0]);
  assign is_swap = op_i[SWAP_BIT];
  assign swapped = {operand_i[HALF-1:0], operand_i[DATA_W-1:HALF]};

  sru_decode u_decode (
    .size_i     (size_i),
    .mem_mode_i (mem_mode_i),
    .cnt_sel_i  (cnt_sel_i),
    .cnt_imm_i  (cnt_imm_i),
    .cnt_reg_i  (cnt_reg_i),
    .cnt_o      (cnt),
    .size_idx_o (size_idx)
  );

  sru_core #(.DATA_W(DATA_W)) u_core (
    .operand_i  (operand_i),
    .cnt_i      (cnt),
    .size_idx_i (size_idx),
    .op_i       (lane_op),
    .x_i        (x_i),
    .full_o     (core_full),
    .x_o        (core_x),
    .n_o        (core_n),
    .z_o        (core_z),
    .v_o        (core_v),
    .c_o        (core_c)
  );

  always_comb begin
    if (is_swap) begin
      res_d = swapped;
      x_d   = x_i;
      n_d   = swapped[DATA_W-1];
      z_d   = (swapped == '0);
      v_d   = 1'b0;
      c_d   = 1'b0;
    end else begin
      res_d = core_full;
      x_d   = core_x;
      n_d   = core_n;
      z_d   = core_z;
      v_d   = core_v;
      c_d   = core_c;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      x_o      <= 1'b0;
      n_o      <= 1'b0;
      z_o      <= 1'b0;
      v_o      <= 1'b0;
      c_o      <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        x_o      <= x_d;
        n_o      <= n_d;
        z_o      <= z_d;
        v_o      <= v_d;
        c_o      <= c_d;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_upper_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_swap && !mem_mode_i && size_i == 2'd0
    |=> result_o[DATA_W-1:8] == $past(operand_i[DATA_W-1:8]));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (is_swap || lane_op != SH_ASL) |=> !v_o);

  assert_rot_keeps_x_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_swap && (lane_op == SH_ROL || lane_op == SH_ROR)
    |=> x_o == $past(x_i));

  assert_mem_one_bit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mem_mode_i && !is_swap && lane_op == SH_LSL
    |=> result_o[15:0] == {$past(operand_i[14:0]), 1'b0} && c_o == $past(operand_i[15]));

  assert_half_swap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_swap
    |=> result_o == {$past(operand_i[HALF-1:0]), $past(operand_i[DATA_W-1:HALF])} && !c_o && !v_o);

  assert_byte_swap_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_swap && !mem_mode_i && !cnt_sel_i && cnt_imm_i == '0 && size_i == 2'd1
    && (lane_op == SH_ROL || lane_op == SH_ROR)
    |=> result_o[15:0] == {$past(operand_i[7:0]), $past(operand_i[15:8])});
endmodule

// File: tb/shift_rotate_unit_bench.sv
module shift_rotate_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic        mem_mode_i = 1'b0;
  logic        cnt_sel_i = 1'b0;
  logic [2:0]  cnt_imm_i = '0;
  logic [5:0]  cnt_reg_i = '0;
  logic [31:0] operand_i = '0;
  logic        x_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        x_o, n_o, z_o, v_o, c_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  shift_rotate_unit u_shift_rotate_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
    .mem_mode_i(mem_mode_i), .cnt_sel_i(cnt_sel_i), .cnt_imm_i(cnt_imm_i),
    .cnt_reg_i(cnt_reg_i), .operand_i(operand_i), .x_i(x_i), .valid_o(valid_o),
    .result_o(result_o), .x_o(x_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
  );

  // bit-serial reference: {result, x, n, z, v, c}
  function automatic logic [36:0] model(input logic [3:0] op, input logic [1:0] sz,
      input logic mem, input logic sel, input logic [2:0] imm, input logic [5:0] creg,
      input logic [31:0] opd, input logic x);
    int w, n;
    logic [31:0] mask, val, res;
    logic xx, c, v, out, sign;
    if (op[3]) begin
      res = {opd[15:0], opd[31:16]};
      return {res, x, res[31], res == 32'd0, 1'b0, 1'b0};
    end
    w = mem ? 16 : (sz == 2'd0 ? 8 : (sz == 2'd1 ? 16 : 32));
    n = mem ? 1 : (sel ? int'(creg) : (imm == 3'd0 ? 8 : int'(imm)));
    mask = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 32'd1);
    val = opd & mask;
    xx = x;
    v = 1'b0;
    c = (op[2:1] == 2'b10) ? x : 1'b0;
    for (int i = 0; i < n; i++) begin
      sign = val[w-1];
      case (op[2:0])
        3'd0: begin out = val[0]; val = (val >> 1) | ({31'd0, sign} << (w-1)); xx = out; end
        3'd1, 3'd3: begin
          out = val[w-1]; val = (val << 1) & mask; xx = out;
          if (op[2:0] == 3'd1 && val[w-1] != out) v = 1'b1;
        end
        3'd2: begin out = val[0]; val = val >> 1; xx = out; end
        3'd4: begin out = val[0]; val = (val >> 1) | ({31'd0, xx} << (w-1)); xx = out; end
        3'd5: begin out = val[w-1]; val = ((val << 1) | {31'd0, xx}) & mask; xx = out; end
        3'd6: begin out = val[0]; val = (val >> 1) | ({31'd0, out} << (w-1)); end
        default: begin out = val[w-1]; val = ((val << 1) | {31'd0, out}) & mask; end
      endcase
      c = out;
    end
    res = (opd & ~mask) | val;
    return {res, xx, val[w-1], val == 32'd0, v, c};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    if (op[3]) return "R11";
    case (op[2:0])
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R8";
      default: return "R7";
    endcase
  endfunction

  // called at a falling edge; drives a request and checks it one clock later
  task automatic run(input logic [3:0] op, input logic [1:0] sz, input logic mem,
      input logic sel, input logic [2:0] imm, input logic [5:0] creg,
      input logic [31:0] opd, input logic x, input string tag);
    logic [36:0] exp, got;
    op_i = op; size_i = sz; mem_mode_i = mem; cnt_sel_i = sel; cnt_imm_i = imm;
    cnt_reg_i = creg; operand_i = opd; x_i = x; valid_i = 1'b1;
    exp = model(op, sz, mem, sel, imm, creg, opd, x);
    @(negedge clk);
    got = {result_o, x_o, n_o, z_o, v_o, c_o};
    checks++;
    if (!valid_o || got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d sz=%0d mem=%0b sel=%0b imm=%0d reg=%0d opd=%h x=%0b: actual valid=%0b %h expected valid=1 %h",
               tag, op, sz, mem, sel, imm, creg, opd, x, valid_o, got, exp);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual still running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] r_op;
    logic [1:0] r_sz;
    logic [5:0] r_reg;
    logic [31:0] r_opd;
    int wsel;
    void'($urandom(32'h00c0_ffee));
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if ({valid_o, result_o, x_o, n_o, z_o, v_o, c_o} !== 38'd0) begin
      errors++;
      $display("FAIL R1 reset: actual %h expected 0", {valid_o, result_o, x_o, n_o, z_o, v_o, c_o});
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R13 byte swap by rotate 8 (immediate 0 encodes 8, R3)
    run(4'd7, 2'd1, 1'b0, 1'b0, 3'd0, 6'd0, 32'hdead_12ab, 1'b0, "R13");
    run(4'd6, 2'd1, 1'b0, 1'b0, 3'd0, 6'd0, 32'h0000_80f1, 1'b1, "R13");
    run(4'd3, 2'd2, 1'b0, 1'b0, 3'd0, 6'd0, 32'h0123_4567, 1'b0, "R3");
    run(4'd2, 2'd0, 1'b0, 1'b0, 3'd5, 6'd0, 32'hffff_ffa0, 1'b0, "R3");
    // R9 zero count per class
    run(4'd3, 2'd2, 1'b0, 1'b1, 3'd0, 6'd0, 32'h8000_0001, 1'b1, "R9");
    run(4'd7, 2'd0, 1'b0, 1'b1, 3'd0, 6'd0, 32'h0000_0081, 1'b0, "R9");
    run(4'd5, 2'd1, 1'b0, 1'b1, 3'd0, 6'd0, 32'h0000_1234, 1'b1, "R9");
    // R4, R5 large counts
    run(4'd2, 2'd0, 1'b0, 1'b1, 3'd0, 6'd40, 32'h1234_56ff, 1'b1, "R4");
    run(4'd3, 2'd1, 1'b0, 1'b1, 3'd0, 6'd16, 32'h0000_0001, 1'b0, "R4");
    run(4'd0, 2'd2, 1'b0, 1'b1, 3'd0, 6'd63, 32'h8000_0000, 1'b0, "R5");
    run(4'd0, 2'd0, 1'b0, 1'b1, 3'd0, 6'd9, 32'h0000_0070, 1'b1, "R5");
    // R6 overflow on last step only, and no overflow with uniform top bits
    run(4'd1, 2'd0, 1'b0, 1'b1, 3'd0, 6'd3, 32'h0000_00f0, 1'b0, "R6");
    run(4'd1, 2'd0, 1'b0, 1'b1, 3'd0, 6'd3, 32'h0000_00e0, 1'b0, "R6");
    run(4'd1, 2'd2, 1'b0, 1'b1, 3'd0, 6'd32, 32'hffff_ffff, 1'b0, "R6");
    // R7, R8 wrap
    run(4'd7, 2'd0, 1'b0, 1'b1, 3'd0, 6'd8, 32'h0000_0081, 1'b1, "R7");
    run(4'd6, 2'd2, 1'b0, 1'b1, 3'd0, 6'd33, 32'h0000_0003, 1'b0, "R7");
    run(4'd5, 2'd0, 1'b0, 1'b1, 3'd0, 6'd9, 32'h0000_0055, 1'b1, "R8");
    run(4'd4, 2'd2, 1'b0, 1'b1, 3'd0, 6'd33, 32'h8000_0001, 1'b0, "R8");
    run(4'd5, 2'd1, 1'b0, 1'b1, 3'd0, 6'd18, 32'h0000_8000, 1'b0, "R8");
    // R10 memory mode ignores count and size
    run(4'd3, 2'd2, 1'b1, 1'b1, 3'd0, 6'd37, 32'habcd_c001, 1'b0, "R10");
    run(4'd4, 2'd0, 1'b1, 1'b0, 3'd3, 6'd0, 32'h5555_0001, 1'b1, "R10");
    // R11 swap and R12 flags on selected size, R2 pass-through
    run(4'd8, 2'd0, 1'b0, 1'b0, 3'd1, 6'd0, 32'h0000_ffff, 1'b1, "R11");
    run(4'd15, 2'd0, 1'b0, 1'b0, 3'd1, 6'd0, 32'h0000_0000, 1'b0, "R11");
    run(4'd3, 2'd0, 1'b0, 1'b0, 3'd1, 6'd0, 32'hffff_ff40, 1'b0, "R12");
    run(4'd2, 2'd3, 1'b0, 1'b0, 3'd4, 6'd0, 32'hf000_000f, 1'b0, "R2");

    // R1 idle cycle
    valid_i = 1'b0;
    @(negedge clk);
    check_bit(valid_o, 1'b0, "R1 idle valid");

    for (int i = 0; i < 3000; i++) begin
      r_op = ($urandom_range(0, 15) == 0) ? 4'(8 + $urandom_range(0, 7)) : 4'($urandom_range(0, 7));
      r_sz = 2'($urandom_range(0, 3));
      wsel = (r_sz == 2'd0) ? 8 : (r_sz == 2'd1 ? 16 : 32);
      r_reg = ($urandom_range(0, 3) == 0) ? 6'(wsel - 2 + $urandom_range(0, 4))
                                          : 6'($urandom_range(0, 63));
      case ($urandom_range(0, 7))
        0: r_opd = 32'hffff_ffff;
        1: r_opd = 32'h1 << $urandom_range(0, 31);
        2: r_opd = 32'h8080_8080;
        default: r_opd = $urandom;
      endcase
      run(r_op, r_sz, ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)),
          3'($urandom_range(0, 7)), r_reg, r_opd, 1'($urandom_range(0, 1)), tag_of(r_op));
    end
    valid_i = 1'b0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule